// File: doc/BRIEF.md
# Self-Timed Clock Enable Controller

This block sits beside a processing core and decides, cycle by cycle, whether that core's clock should run. It is driven from the free-running clock. It follows the core's activity through a three-state machine: Idle, then Ready, then Run. A one-cycle strobe from the system bus starts a job. A one-cycle strobe from the core ends it. The clock enable follows from that state alone, so no software register is involved.

Every state other than Idle is a working state, and the core clock runs in all of them. After a job ends, the controller returns to Idle. The clock keeps running for a parameterised hold-off of `HOLDOFF` consecutive idle cycles, 4 by default, and then stops.

The enable passes through a level-sensitive latch that is open only while the free clock is low. The gated clock is the free clock ANDed with the latch output, so it can never carry a shortened pulse. A request arriving while the clock is stopped raises the enable without waiting for a clock edge. The core therefore sees a clock pulse on the same edge that moves the controller to Ready.

Top module: `cg_auto_ctrl`

## Requirements
- R1: While and right after reset, the state output reads Idle (code 0), busy is low and the clock enable is high.
- R2: A request seen in Idle (code 0) moves the state to Ready (code 1) at the next rising edge, and Ready always moves to Run (code 2) at the edge after.
- R3: Run persists while done is low, and a done seen in Run returns the state to Idle at the next edge.
- R4: Busy is high exactly when the state is not Idle.
- R5: The clock enable is high in every working state (Ready and Run).
- R6: After entering Idle, whether from reset or from Run, the gated clock delivers exactly HOLDOFF rising edges and then stays low, with the enable low, for as long as no request arrives.
- R7: A request raised while the clock is stopped drives the enable high within the following low phase of the free clock, so the gated clock pulses on the very edge that moves the state to Ready.
- R8: The clock enable never changes while the free clock is high, and the gated clock is never high while the free clock is low.
- R9: Done has no effect outside Run, and a request has no effect outside Idle.
- R10: The hold-off count restarts from zero on every return to Idle, so each job is followed by a full hold-off window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running clock |
| rst_i | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Job request strobe from the system bus |
| done_i | input | 1 | Job finished strobe from the core |
| clk_en_o | output | 1 | Latched clock enable |
| gclk_o | output | 1 | Gated clock for the core |
| busy_o | output | 1 | High while a job is in progress |
| state_o | output | 2 | Controller state: 0 Idle, 1 Ready, 2 Run |

## Verification
The bench counts gated-clock edges after each entry into Idle. An off-by-one in the hold-off counter shows up there as HOLDOFF plus or minus one pulses, and a counter that is not cleared after a job shows up as a short or missing window. The bench wakes the block while it is fully gated and checks for a gated pulse on the Ready edge. A design that only re-enables from registered state would lose that edge and leave the core one cycle behind. Stray strobes are also sent: done in Idle and Ready, and a request in Run. A design that honours them would skip a state or abort a job. A monitor samples the enable twice in every high phase and checks the gated clock in every low phase; a design whose enable is not latched would show a change there.

// File: rtl/cg_pkg.sv
package cg_pkg;
  localparam int CG_STATE_W = 2;

  typedef enum logic [CG_STATE_W-1:0] {
    CG_IDLE  = 2'd0,
    CG_READY = 2'd1,
    CG_RUN   = 2'd2
  } cg_state_e;
endpackage

// File: rtl/cg_fsm.sv
module cg_fsm
  import cg_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_i,
  input  logic      req_i,
  input  logic      done_i,
  output cg_state_e state_o,
  output logic      busy_o,
  output logic      idle_hold_o
);
  cg_state_e state_q, state_d;
  logic      busy_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      CG_IDLE:  if (req_i)  state_d = CG_READY;
      CG_READY:             state_d = CG_RUN;
      CG_RUN:   if (done_i) state_d = CG_IDLE;
      default:              state_d = CG_IDLE;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q <= CG_IDLE;
      busy_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      busy_q  <= (state_d != CG_IDLE);
    end
  end

  // Idle and not leaving it at this edge: hold-off keeps counting
  assign idle_hold_o = (state_q == CG_IDLE) && !req_i;
  assign state_o     = state_q;
  assign busy_o      = busy_q;
endmodule

// File: rtl/cg_holdoff.sv
module cg_holdoff #(
  parameter int HOLDOFF = 4
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic hold_i,
  output logic expired_o
);
  localparam int CNT_W = (HOLDOFF < 1) ? 1 : $clog2(HOLDOFF + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(HOLDOFF);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || !hold_i) cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == LIMIT);
endmodule

// File: rtl/cg_gate.sv
module cg_gate (
  input  logic clk_i,
  input  logic en_i,
  output logic en_o,
  output logic gclk_o
);
  logic en_lat;

  // Transparent while the clock is low; frozen through the high phase
  always_latch begin
    if (!clk_i) en_lat = en_i;
  end

  assign en_o   = en_lat;
  assign gclk_o = clk_i & en_lat;
endmodule

// File: rtl/cg_auto_ctrl.sv
module cg_auto_ctrl
  import cg_pkg::*;
#(
  parameter int HOLDOFF = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_i,
  input  logic                  req_i,
  input  logic                  done_i,
  output logic                  clk_en_o,
  output logic                  gclk_o,
  output logic                  busy_o,
  output logic [CG_STATE_W-1:0] state_o
);
  cg_state_e state;
  logic      idle_hold;
  logic      expired;
  logic      en_req;

  cg_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .req_i       (req_i),
    .done_i      (done_i),
    .state_o     (state),
    .busy_o      (busy_o),
    .idle_hold_o (idle_hold)
  );

  cg_holdoff #(.HOLDOFF(HOLDOFF)) u_holdoff (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .hold_i    (idle_hold),
    .expired_o (expired)
  );

  // Request path is combinational so a stopped clock restarts on the Ready edge
  assign en_req = (state != CG_IDLE) || req_i || !expired;

  cg_gate u_gate (
    .clk_i  (clk_i),
    .en_i   (en_req),
    .en_o   (clk_en_o),
    .gclk_o (gclk_o)
  );

  assign state_o = state;
endmodule

// File: rtl/cg_auto_ctrl_chk.sv
module cg_auto_ctrl_chk #(
  parameter int HOLDOFF = 4
) (
  input logic       clk_i,
  input logic       rst_i,
  input logic       req_i,
  input logic       done_i,
  input logic       clk_en_o,
  input logic       busy_o,
  input logic [1:0] state_o
);
  localparam int RW = $clog2(HOLDOFF + 2);
  logic [RW-1:0] idle_run;

  always_ff @(posedge clk_i) begin
    if (rst_i || state_o != 2'd0 || req_i) idle_run <= '0;
    else if (idle_run < RW'(HOLDOFF)) idle_run <= idle_run + 1'b1;
  end

  a_r2_idle_to_ready: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_o == 2'd0 && req_i) |=> state_o == 2'd1);
  a_r2_ready_to_run: assert property (@(posedge clk_i) disable iff (rst_i)
    state_o == 2'd1 |=> state_o == 2'd2);
  a_r3_run_holds: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_o == 2'd2 && !done_i) |=> state_o == 2'd2);
  a_r3_done_to_idle: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_o == 2'd2 && done_i) |=> state_o == 2'd0);
  a_r4_busy_match: assert property (@(posedge clk_i) disable iff (rst_i)
    busy_o == (state_o != 2'd0));
  a_r5_en_working: assert property (@(posedge clk_i) disable iff (rst_i)
    state_o != 2'd0 |-> clk_en_o);
  a_r6_window_on: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_o == 2'd0 && idle_run < RW'(HOLDOFF)) |-> clk_en_o);
  a_r6_gated_off: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_o == 2'd0 && idle_run >= RW'(HOLDOFF) && !req_i) |-> !clk_en_o);
  a_r7_req_enables: assert property (@(posedge clk_i) disable iff (rst_i)
    req_i |-> clk_en_o);
  a_r9_no_bad_code: assert property (@(posedge clk_i) disable iff (rst_i)
    state_o != 2'd3);
endmodule

bind cg_auto_ctrl cg_auto_ctrl_chk #(.HOLDOFF(HOLDOFF)) chk_i (
  .clk_i    (clk_i),
  .rst_i    (rst_i),
  .req_i    (req_i),
  .done_i   (done_i),
  .clk_en_o (clk_en_o),
  .busy_o   (busy_o),
  .state_o  (state_o)
);

// File: tb/cg_auto_ctrl_tb_top.sv
`timescale 1ns/1ps
module cg_auto_ctrl_tb_top;
  localparam int HOLDOFF = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req = 1'b0;
  logic       done = 1'b0;
  logic       en, gclk, busy;
  logic [1:0] state;

  int n_chk = 0;
  int n_fail = 0;
  int pulses = 0;
  int glitches = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  cg_auto_ctrl #(.HOLDOFF(HOLDOFF)) dut_i (
    .clk_i(clk), .rst_i(rst), .req_i(req), .done_i(done),
    .clk_en_o(en), .gclk_o(gclk), .busy_o(busy), .state_o(state)
  );

  always @(posedge gclk) pulses++;

  // R8 monitor: enable steady through each high phase, gated clock low in low phase
  initial forever begin
    logic v;
    @(posedge clk); #1 v = en;
    #3 if (en !== v) glitches++;
    @(negedge clk); #1 if (gclk !== 1'b0) glitches++;
  end

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
  endtask

  task automatic t_reset;
    tick(3);
    chk(state == 2'd0, "R1 state", state, 0);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(en == 1'b1, "R1 enable", en, 1);
    rst = 1'b0;
  endtask

  task automatic t_holdoff_after_reset;
    int base;
    base = pulses;
    tick(10);
    chk(pulses - base == HOLDOFF, "R6 pulses after reset", pulses - base, HOLDOFF);
    chk(en == 1'b0, "R6 gated after reset", en, 0);
    chk(state == 2'd0, "R1 stays idle", state, 0);
  endtask

  task automatic t_job;
    int base;
    req = 1'b1;
    tick();
    req = 1'b0;
    chk(state == 2'd1, "R2 ready", state, 1);
    chk(busy == 1'b1, "R4 busy in ready", busy, 1);
    tick();
    chk(state == 2'd2, "R2 run", state, 2);
    chk(en == 1'b1, "R5 enable in run", en, 1);
    tick(3);
    chk(state == 2'd2, "R3 run holds", state, 2);
    chk(busy == 1'b1, "R4 busy in run", busy, 1);
    done = 1'b1;
    tick();
    done = 1'b0;
    chk(state == 2'd0, "R3 done to idle", state, 0);
    chk(busy == 1'b0, "R4 busy clear", busy, 0);
    base = pulses;
    tick(10);
    chk(pulses - base == HOLDOFF, "R10 window after job", pulses - base, HOLDOFF);
    chk(en == 1'b0, "R6 gated after job", en, 0);
  endtask

  task automatic t_wake;
    int base;
    base = pulses;
    req = 1'b1;
    @(negedge clk); #1;
    chk(en == 1'b1, "R7 enable before edge", en, 1);
    chk(state == 2'd0, "R7 still idle", state, 0);
    @(posedge clk); #2;
    req = 1'b0;
    chk(state == 2'd1, "R7 ready", state, 1);
    chk(pulses - base == 1, "R7 pulse on ready edge", pulses - base, 1);
  endtask

  task automatic t_ignore;
    // now in Ready: done must not skip Run
    done = 1'b1;
    tick();
    done = 1'b0;
    chk(state == 2'd2, "R9 done in ready ignored", state, 2);
    req = 1'b1;
    tick(2);
    req = 1'b0;
    chk(state == 2'd2, "R9 req in run ignored", state, 2);
    done = 1'b1;
    tick();
    chk(state == 2'd0, "R3 back idle", state, 0);
    tick(8);
    done = 1'b0;
    chk(state == 2'd0, "R9 done in idle ignored", state, 0);
    chk(en == 1'b0, "R9 done keeps gating", en, 0);
    chk(busy == 1'b0, "R4 idle busy low", busy, 0);
  endtask

  initial begin
    t_reset();
    t_holdoff_after_reset();
    t_job();
    t_wake();
    t_ignore();
    chk(glitches == 0, "R8 glitch-free enable", glitches, 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule